// File: doc/BRIEF.md
# Battery charge cycle sequencer

This block is the central state machine of a fast charger for nickel-based cells. Analog comparators, the converter and the indicator drivers live elsewhere. The block receives their results as single-bit flags:

- cell voltage above its ceiling, or below the end-of-discharge floor
- temperature inside its valid window
- temperature past the hot cutoff, or past the cold fault level
- a termination flag from the slope detector

It also takes an active-low discharge request, an active-low inhibit, two three-level timer-mode selects and a one-per-second tick.

From these inputs it walks a charge cycle through its phases. It can run an optional discharge to the floor first. It then qualifies the cell, fast-charges under a safety timer, and may follow with a time-limited top-off. A cell that fails qualification waits in a pending phase: reduced charge for a limited time, then unlimited trickle. An over-voltage event stops charging at once. A short timed window then decides between a full cell and a removed one.

The outputs are a phase code, a discharge enable, an output-enable (low while inhibited, meaning the outside drivers float) and a safety-timer expiry flag. All timer lengths are parameters counted in ticks.

Top module: `chg_seq`

## Requirements
- R1: Phase codes: 0 start/suspended, 1 discharge, 2 pending reduced-rate, 3 pending trickle, 4 fast, 5 top-off, 6 complete (trickle), 7 battery absent, 8 over-voltage hold. While reset is asserted, the outputs are phase 0, out_en 0, dis_en 0 and tmr_expired 0.
- R2: While inhibit_n is low, the next edge gives phase 0 and out_en 0. The discharge request is ignored. When inhibit_n returns high, the next edge starts a new cycle and sets out_en to 1.
- R3: A new cycle resolves in one edge, in this priority order:
  - discharge request held low: phase 1
  - otherwise cell above ceiling: phase 7
  - otherwise voltage between the levels and temperature in window: phase 4
  - otherwise: pending.
- R4: A falling edge of dis_cmd_n moves any state to phase 1 at the next edge.
- R5: dis_en is 1 only in phase 1. When the cell falls below the floor, the next edge applies the qualification of R3 without another discharge, even if the request is still held low.
- R6: The pending phase is entered as phase 2 when top-off is enabled, and as phase 3 otherwise. Passing qualification leads to phase 4. Phase 2 moves to phase 3 once the top-off length in ticks has elapsed.
- R7: Fast charge ends on any of slope_term, temp_hot, temp_cold, or safety-timer expiry. tmr_expired rises in the cycle after the tick that reaches the limit. The next edge gives phase 5 if top-off is enabled, and phase 6 otherwise.
- R8: Top-off lasts floor(safety × 235 / 1000) ticks, counted afresh from its entry. Only temp_hot, its timeout or over-voltage end it. slope_term and temp_cold are ignored there.
- R9: cell_hi in phases 2–6 gives phase 8 at the next edge.
- R10: In phase 8, cell_hi going low gives phase 6. If cell_hi is still high once OV_TICKS ticks have been counted, the block gives phase 7.
- R11: In phase 7, cell_hi going low returns to phase 0, and the cycle resolves per R3 at the following edge.
- R12: Each timer select is 2 bits: 00 low, 01 float, 10 or 11 high. The safety time is SAFE_UNIT << k. Pairs are written (tm_a, tm_b):
  - tm_b low: tm_a low k=3, float k=2, high k=1; top-off off
  - tm_b float: tm_a low or float k=0 with top-off off; tm_a high k=2 with top-off on
  - tm_b high: tm_a low k=1, float k=0, high k=0; top-off on.
- R13: Phase 6 holds regardless of ticks, slope_term or temperature flags until over-voltage, a discharge request or inhibit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset (power-up) |
| tick | input | 1 | one-cycle time-base pulse |
| inhibit_n | input | 1 | active-low suspend |
| dis_cmd_n | input | 1 | active-low discharge request |
| cell_hi | input | 1 | cell above the ceiling |
| cell_lo | input | 1 | cell below the floor |
| temp_ok | input | 1 | temperature inside its window |
| temp_hot | input | 1 | temperature past the hot cutoff |
| temp_cold | input | 1 | temperature past the cold fault level |
| slope_term | input | 1 | slope detector termination |
| tm_a | input | 2 | timer-mode select A |
| tm_b | input | 2 | timer-mode select B |
| phase | output | 4 | phase code |
| out_en | output | 1 | external drivers enabled |
| dis_en | output | 1 | discharge enable |
| tmr_expired | output | 1 | safety or top-off limit reached |

## Verification
Every phase change is registered, so a flag change lands in phase one edge later. The bench drives inputs on the falling edge and reads the result on the next falling edge.

Timer results take two edges. The edge that consumes the limiting tick raises tmr_expired while the phase is unchanged, and the phase moves on at the edge after. The bench checks both points.

A new cycle after inhibit release takes one edge. A return from battery absent takes two, because it shows phase 0 in between. The checks count exactly that.

// File: rtl/chg_pkg.sv
package chg_pkg;

  typedef enum logic [3:0] {
    PH_START    = 4'd0,
    PH_DISCH    = 4'd1,
    PH_PEND_RED = 4'd2,
    PH_PEND_TRK = 4'd3,
    PH_FAST     = 4'd4,
    PH_TOPOFF   = 4'd5,
    PH_DONE     = 4'd6,
    PH_ABSENT   = 4'd7,
    PH_OVHOLD   = 4'd8
  } phase_t;

  typedef enum logic [1:0] {LV_LOW, LV_FLOAT, LV_HIGH} level_t;

  typedef struct packed {
    logic [1:0] shift;
    logic       topoff;
  } tmode_t;

  function automatic level_t level_of(input logic [1:0] pin);
    if (pin == 2'b00)      return LV_LOW;
    else if (pin == 2'b01) return LV_FLOAT;
    else                   return LV_HIGH;
  endfunction

  // Safety-time exponent and top-off enable from the two selects.
  function automatic tmode_t decode_tmode(input logic [1:0] a, input logic [1:0] b);
    tmode_t m;
    level_t la, lb;
    la = level_of(a);
    lb = level_of(b);
    m = '{shift: 2'd0, topoff: 1'b0};
    case (lb)
      LV_LOW: begin
        m.topoff = 1'b0;
        m.shift  = (la == LV_LOW) ? 2'd3 : (la == LV_FLOAT) ? 2'd2 : 2'd1;
      end
      LV_FLOAT: begin
        m.topoff = (la == LV_HIGH);
        m.shift  = (la == LV_HIGH) ? 2'd2 : 2'd0;
      end
      default: begin
        m.topoff = 1'b1;
        m.shift  = (la == LV_LOW) ? 2'd1 : 2'd0;
      end
    endcase
    return m;
  endfunction

  function automatic logic [31:0] topoff_ticks(input logic [31:0] safe);
    return (safe * 32'd235) / 32'd1000;
  endfunction

  function automatic logic is_charging(input phase_t p);
    return (p == PH_PEND_RED) || (p == PH_PEND_TRK) || (p == PH_FAST) ||
           (p == PH_TOPOFF)   || (p == PH_DONE);
  endfunction

endpackage

// File: rtl/chg_limits.sv
module chg_limits
  import chg_pkg::*;
#(
  parameter int SAFE_UNIT = 2340,
  parameter int OV_TICKS  = 2,
  parameter int CNT_W     = 24
) (
  input  logic [1:0]       tm_a,
  input  logic [1:0]       tm_b,
  input  phase_t           ph,
  output logic [CNT_W-1:0] limit,
  output logic             topoff_en
);
  localparam logic [CNT_W-1:0] UNIT   = CNT_W'(SAFE_UNIT);
  localparam logic [CNT_W-1:0] OV_LIM = CNT_W'(OV_TICKS);

  tmode_t           md;
  logic [CNT_W-1:0] safe_len;
  logic [CNT_W-1:0] top_len;

  assign md        = decode_tmode(tm_a, tm_b);
  assign topoff_en = md.topoff;
  assign safe_len  = UNIT << md.shift;
  assign top_len   = CNT_W'(topoff_ticks(32'(safe_len)));

  always_comb begin
    case (ph)
      PH_FAST:                limit = safe_len;
      PH_PEND_RED, PH_TOPOFF: limit = top_len;
      PH_OVHOLD:              limit = OV_LIM;
      default:                limit = '1;
    endcase
  end
endmodule

// File: rtl/chg_timer.sv
module chg_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             reached
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cnt <= '0;
    else if (restart)                   cnt <= '0;
    else if (tick && (cnt != CNT_MAX))  cnt <= cnt + CNT_W'(1);
  end

  assign reached = (cnt >= limit);

  // R8: every phase entry starts its count from zero
  assert_restart_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/chg_seq.sv
module chg_seq
  import chg_pkg::*;
#(
  parameter int SAFE_UNIT = 2340,
  parameter int OV_TICKS  = 2,
  parameter int CNT_W     = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       inhibit_n,
  input  logic       dis_cmd_n,
  input  logic       cell_hi,
  input  logic       cell_lo,
  input  logic       temp_ok,
  input  logic       temp_hot,
  input  logic       temp_cold,
  input  logic       slope_term,
  input  logic [1:0] tm_a,
  input  logic [1:0] tm_b,
  output logic [3:0] phase,
  output logic       out_en,
  output logic       dis_en,
  output logic       tmr_expired
);
  phase_t           state, nxt;
  logic             dis_prev;
  logic [CNT_W-1:0] limit;
  logic             topoff_en, reached;

  // Named internal events
  logic   dis_fall, qual_ok, fast_stop, restart;
  phase_t qual_tgt;

  chg_limits #(.SAFE_UNIT(SAFE_UNIT), .OV_TICKS(OV_TICKS), .CNT_W(CNT_W)) u_limits (
    .tm_a(tm_a), .tm_b(tm_b), .ph(state), .limit(limit), .topoff_en(topoff_en));

  chg_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tick(tick),
    .limit(limit), .reached(reached));

  assign dis_fall  = dis_prev && !dis_cmd_n;
  assign qual_ok   = !cell_hi && !cell_lo && temp_ok;
  assign qual_tgt  = cell_hi ? PH_ABSENT :
                     qual_ok ? PH_FAST   :
                     (topoff_en ? PH_PEND_RED : PH_PEND_TRK);
  assign fast_stop = slope_term || temp_hot || temp_cold || reached;

  always_comb begin
    nxt = state;
    if (!inhibit_n)                        nxt = PH_START;
    else if (dis_fall)                     nxt = PH_DISCH;
    else if (is_charging(state) && cell_hi) nxt = PH_OVHOLD;
    else begin
      case (state)
        PH_START:    nxt = !dis_cmd_n ? PH_DISCH : qual_tgt;
        PH_DISCH:    if (cell_lo) nxt = qual_tgt;
        PH_PEND_RED: if (qual_ok) nxt = PH_FAST;
                     else if (reached) nxt = PH_PEND_TRK;
        PH_PEND_TRK: if (qual_ok) nxt = PH_FAST;
        PH_FAST:     if (fast_stop) nxt = topoff_en ? PH_TOPOFF : PH_DONE;
        PH_TOPOFF:   if (temp_hot || reached) nxt = PH_DONE;
        PH_OVHOLD:   if (!cell_hi) nxt = PH_DONE;
                     else if (reached) nxt = PH_ABSENT;
        PH_ABSENT:   if (!cell_hi) nxt = PH_START;
        PH_DONE:     nxt = PH_DONE;
        default:     nxt = PH_START;
      endcase
    end
  end

  assign restart = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PH_START;
      dis_prev <= 1'b1;
      out_en   <= 1'b0;
    end else begin
      state    <= nxt;
      dis_prev <= dis_cmd_n;
      out_en   <= inhibit_n;
    end
  end

  assign phase       = state;
  assign dis_en      = (state == PH_DISCH);
  assign tmr_expired = reached &&
                       ((state == PH_FAST) || (state == PH_TOPOFF) || (state == PH_PEND_RED));

  // R2: inhibit suspends everything
  assert_inhibit_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_n |=> (phase == 4'd0 && !out_en && !dis_en));

  // R4: discharge request edge wins from any state
  assert_dis_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_n && dis_fall) |=> dis_en);

  // R5: reaching the floor leaves discharge
  assert_dis_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_n && state == PH_DISCH && cell_lo && !dis_fall) |=> !dis_en);

  // R9: over-voltage halts charging
  assert_ov_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_n && !dis_fall && cell_hi && is_charging(state)) |=> (phase == 4'd8));

  // R7: expiry ends fast charge
  assert_fast_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_n && !dis_fall && !cell_hi && state == PH_FAST && tmr_expired)
      |=> (phase == 4'd5 || phase == 4'd6));

  // R13: complete phase holds
  assert_done_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit_n && !dis_fall && !cell_hi && state == PH_DONE) |=> $stable(phase));
endmodule

// File: tb/chg_seq_bench.sv
`timescale 1ns/1ps
module chg_seq_bench;
  localparam int SAFE_UNIT = 8;
  localparam int OV_TICKS  = 2;
  localparam int CNT_W     = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, inhibit_n = 1'b1, dis_cmd_n = 1'b1;
  logic cell_hi = 1'b0, cell_lo = 1'b0, temp_ok = 1'b1;
  logic temp_hot = 1'b0, temp_cold = 1'b0, slope_term = 1'b0;
  logic [1:0] tm_a = 2'b00, tm_b = 2'b00;
  logic [3:0] phase;
  logic out_en, dis_en, tmr_expired;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  chg_seq #(.SAFE_UNIT(SAFE_UNIT), .OV_TICKS(OV_TICKS), .CNT_W(CNT_W)) u_chg_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .inhibit_n(inhibit_n),
    .dis_cmd_n(dis_cmd_n), .cell_hi(cell_hi), .cell_lo(cell_lo),
    .temp_ok(temp_ok), .temp_hot(temp_hot), .temp_cold(temp_cold),
    .slope_term(slope_term), .tm_a(tm_a), .tm_b(tm_b), .phase(phase),
    .out_en(out_en), .dis_en(dis_en), .tmr_expired(tmr_expired));

  // Expected lengths, written from the requirements
  function automatic int safe_len(input int k);
    return SAFE_UNIT * (1 << k);
  endfunction

  function automatic int top_len(input int s);
    return (s * 47) / 200;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] a, input logic [1:0] b);
    @(negedge clk);
    rst_n = 1'b0;
    tick = 0; inhibit_n = 1; dis_cmd_n = 1; cell_hi = 0; cell_lo = 0;
    temp_ok = 1; temp_hot = 0; temp_cold = 0; slope_term = 0;
    tm_a = a; tm_b = b;
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(2'b10, 2'b01);
    chk("R1", "phase at reset", phase, 0);
    chk("R1", "out_en at reset", out_en, 0);
    chk("R1", "dis_en at reset", dis_en, 0);
    chk("R1", "tmr_expired at reset", tmr_expired, 0);
  endtask

  // R12 (H,F): k=2, top-off on; R7 expiry; R8 top-off length and ignores
  task automatic t_fast_topoff();
    int s, t;
    s = safe_len(2);
    t = top_len(s);
    do_reset(2'b10, 2'b01);
    step(1);
    chk("R3", "qualified start", phase, 4);
    chk("R2", "out_en after start", out_en, 1);
    for (int i = 0; i < s - 1; i++) pulse_tick();
    chk("R7", "no expiry before limit", tmr_expired, 0);
    pulse_tick();
    chk("R7", "expiry at limit", tmr_expired, 1);
    chk("R7", "still fast at expiry", phase, 4);
    step(1);
    chk("R7", "fast to top-off", phase, 5);
    chk("R8", "timer restarted", tmr_expired, 0);
    slope_term = 1; temp_cold = 1;
    step(2);
    chk("R8", "slope and cold ignored", phase, 5);
    slope_term = 0; temp_cold = 0;
    for (int i = 0; i < t - 1; i++) pulse_tick();
    chk("R8", "top-off before length", tmr_expired, 0);
    pulse_tick();
    chk("R8", "top-off expiry", tmr_expired, 1);
    step(1);
    chk("R8", "top-off to complete", phase, 6);
    slope_term = 1; temp_hot = 1; temp_ok = 0;
    for (int i = 0; i < 3 * s; i++) pulse_tick();
    chk("R13", "complete holds", phase, 6);
  endtask

  // R12 (L,L): k=3, no top-off; R6 pending trickle entry
  task automatic t_no_topoff();
    do_reset(2'b00, 2'b00);
    cell_lo = 1;
    step(1);
    chk("R6", "pending trickle entry", phase, 3);
    for (int i = 0; i < 20; i++) pulse_tick();
    chk("R6", "trickle has no limit", phase, 3);
    cell_lo = 0;
    step(1);
    chk("R6", "trickle to fast", phase, 4);
    slope_term = 1;
    step(1);
    chk("R7", "slope ends fast, no top-off", phase, 6);
  endtask

  // R12 (L,H): k=1, top-off on; R6 reduced pending with timeout
  task automatic t_pending();
    int t;
    t = top_len(safe_len(1));
    do_reset(2'b00, 2'b10);
    temp_ok = 0;
    step(1);
    chk("R6", "pending reduced entry", phase, 2);
    for (int i = 0; i < t - 1; i++) pulse_tick();
    chk("R6", "reduced before timeout", phase, 2);
    pulse_tick();
    chk("R6", "reduced timeout flag", tmr_expired, 1);
    step(1);
    chk("R6", "reduced to trickle", phase, 3);
    temp_ok = 1;
    step(1);
    chk("R6", "qualified to fast", phase, 4);
    temp_hot = 1;
    step(1);
    chk("R7", "hot ends fast", phase, 5);
    step(1);
    chk("R8", "hot ends top-off", phase, 6);
    do_reset(2'b01, 2'b10);
    step(1);
    temp_cold = 1;
    step(1);
    chk("R7", "cold ends fast", phase, 5);
  endtask

  task automatic t_overvolt();
    do_reset(2'b10, 2'b10);
    step(1);
    cell_hi = 1;
    step(1);
    chk("R9", "fast to over-voltage hold", phase, 8);
    cell_hi = 0;
    step(1);
    chk("R10", "short over-voltage is full", phase, 6);
    cell_hi = 1;
    step(1);
    chk("R9", "complete to over-voltage hold", phase, 8);
    for (int i = 0; i < OV_TICKS; i++) pulse_tick();
    chk("R10", "hold until window ends", phase, 8);
    step(1);
    chk("R10", "long over-voltage is absent", phase, 7);
    cell_hi = 0;
    step(1);
    chk("R11", "absent to start", phase, 0);
    step(1);
    chk("R11", "new cycle after replacement", phase, 4);
    do_reset(2'b10, 2'b10);
    cell_hi = 1;
    step(1);
    chk("R3", "start with high cell", phase, 7);
  endtask

  task automatic t_discharge();
    do_reset(2'b10, 2'b10);
    dis_cmd_n = 0;
    step(1);
    chk("R3", "held request starts discharge", phase, 1);
    chk("R5", "dis_en in discharge", dis_en, 1);
    cell_lo = 1;
    step(1);
    chk("R5", "floor reached, pending", phase, 2);
    chk("R5", "dis_en released", dis_en, 0);
    dis_cmd_n = 1; cell_lo = 0;
    step(1);
    chk("R6", "pending to fast", phase, 4);
    dis_cmd_n = 0;
    step(1);
    chk("R4", "request edge from fast", phase, 1);
    step(3);
    chk("R5", "discharge waits for floor", phase, 1);
  endtask

  task automatic t_inhibit();
    do_reset(2'b10, 2'b10);
    step(1);
    inhibit_n = 0;
    step(1);
    chk("R2", "inhibit phase", phase, 0);
    chk("R2", "inhibit out_en", out_en, 0);
    dis_cmd_n = 0;
    step(1);
    chk("R2", "request ignored", dis_en, 0);
    dis_cmd_n = 1;
    step(1);
    inhibit_n = 1;
    step(1);
    chk("R2", "release starts cycle", phase, 4);
    chk("R2", "release out_en", out_en, 1);
  endtask

  initial begin
    t_reset();
    t_fast_topoff();
    t_no_topoff();
    t_pending();
    t_overvolt();
    t_discharge();
    t_inhibit();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule